// File: doc/BRIEF.md
# Overload Hiccup Supervisor

This block watches one output channel of a power stage for overload. It counts cycles of the converter clock, which runs at about 220 kHz. It has two modes. In pass-through mode it only reports an overload flag, one cycle behind the overcurrent comparator, and it never removes the output. In hiccup mode the first overload after start-up switches the output off for a long rest interval. The output then comes back on for a short trial window. The block repeats this rest and trial until a whole trial window passes with no overload. It then returns to normal running and lowers the flag.

Both interval lengths are parameters, given in converter clock cycles. The defaults are 198000 cycles for the rest interval and 4400 cycles for the trial window, about 900 ms and 20 ms. While soft-start has not finished, the block ignores the comparator and holds the flag low. Dropping the channel enable returns the block to idle.

All pins are plain level signals that are sampled on each clock edge. No handshake is involved.

Top module: `hiccup_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `out_en` and `olf` are both 0.
- R2: A cycle that samples `chan_en` low gives `out_en`=0 and `olf`=0 after that edge. The first edge that samples `chan_en` high in idle gives `out_en`=1 and `olf`=0.
- R3: While `chan_en`=1 and `ss_done`=0, each edge gives `out_en`=1 and `olf`=0, whatever `oc_det` and `static_mode` are.
- R4: With `static_mode`=1 and the block enabled, `out_en` stays 1. After each edge where `ss_done`=1 and the output is on, `olf` equals the `oc_det` value sampled at that edge.
- R5: In hiccup mode (`static_mode`=0), an edge that samples `oc_det`=1 while the output runs normally gives `out_en`=0 and `olf`=1.
- R6: The rest interval lasts exactly OFF_CYC cycles. `out_en` is 0 after the trip edge and after the next OFF_CYC-1 edges, and it is 1 after the following edge.
- R7: A trial window lasts exactly ON_CYC cycles with `out_en`=1. If `oc_det` is 0 on every edge of the window, `olf` clears after the window's last edge and the output keeps running.
- R8: If `oc_det` is 1 on any edge of a trial window, the output is removed again after the window's last edge, and a new rest interval of OFF_CYC cycles begins.
- R9: If `static_mode` is sampled high during a rest interval or a trial window, the hiccup cycle ends. After that edge `out_en`=1, and `olf` equals the sampled `oc_det`.
- R10: `olf` stays 1 for the whole rest interval and the whole trial window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock (about 220 kHz) |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable; low forces idle |
| ss_done | input | 1 | Soft-start finished |
| static_mode | input | 1 | 1 = flag pass-through, 0 = hiccup protection |
| oc_det | input | 1 | Overcurrent comparator output |
| out_en | output | 1 | Gate for the converter and linear stage |
| olf | output | 1 | Overload status flag |

## Verification
The bench builds the block with OFF_CYC=20 and ON_CYC=5 instead of the long defaults. The boundaries then sit a few dozen cycles apart: the exact edge where a rest interval ends, the exact edge where a trial window ends, and a back-to-back failed retry. This lets the bench check every edge around those boundaries, and it also brings a reset in the middle of a rest interval within reach.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    HC_IDLE  = 2'd0,
    HC_RUN   = 2'd1,
    HC_OFF   = 2'd2,
    HC_RETRY = 2'd3
  } hc_state_e;
endpackage

// File: rtl/hiccup_timer.sv
module hiccup_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr)        cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
  import hiccup_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int OFF_CYC = 20,
  parameter int ON_CYC  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             ss_done,
  input  logic             static_mode,
  input  logic             oc_det,
  input  logic             tmr_zero,
  output logic             tmr_clr,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             out_en,
  output logic             olf
);
  localparam logic [CNT_W-1:0] OFF_LD = CNT_W'(OFF_CYC - 1);
  localparam logic [CNT_W-1:0] ON_LD  = CNT_W'(ON_CYC - 1);

  hc_state_e state_q, state_d;
  logic      olf_q, olf_d;
  logic      dirty_q, dirty_d;

  always_comb begin
    state_d  = state_q;
    olf_d    = olf_q;
    dirty_d  = dirty_q;
    tmr_clr  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = OFF_LD;
    if (!chan_en) begin
      state_d = HC_IDLE;
      olf_d   = 1'b0;
      dirty_d = 1'b0;
      tmr_clr = 1'b1;
    end else if (!ss_done) begin
      // soft-start: comparator ignored, flag held low
      state_d = HC_RUN;
      olf_d   = 1'b0;
      dirty_d = 1'b0;
      tmr_clr = 1'b1;
    end else begin
      unique case (state_q)
        HC_IDLE: begin
          state_d = HC_RUN;
          olf_d   = 1'b0;
        end
        HC_RUN: begin
          if (static_mode) begin
            olf_d = oc_det;
          end else if (oc_det) begin
            state_d  = HC_OFF;
            olf_d    = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = OFF_LD;
          end else begin
            olf_d = 1'b0;
          end
        end
        HC_OFF: begin
          if (static_mode) begin
            state_d = HC_RUN;
            olf_d   = oc_det;
            tmr_clr = 1'b1;
          end else if (tmr_zero) begin
            state_d  = HC_RETRY;
            dirty_d  = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = ON_LD;
          end
        end
        HC_RETRY: begin
          if (static_mode) begin
            state_d = HC_RUN;
            olf_d   = oc_det;
            tmr_clr = 1'b1;
          end else if (tmr_zero) begin
            if (dirty_q || oc_det) begin
              state_d  = HC_OFF;
              tmr_load = 1'b1;
              tmr_val  = OFF_LD;
            end else begin
              state_d = HC_RUN;
              olf_d   = 1'b0;
            end
          end else begin
            dirty_d = dirty_q | oc_det;
          end
        end
        default: state_d = HC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HC_IDLE;
      olf_q   <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      olf_q   <= olf_d;
      dirty_q <= dirty_d;
    end
  end

  assign out_en = (state_q == HC_RUN) || (state_q == HC_RETRY);
  assign olf    = olf_q;
endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl #(
  parameter int OFF_CYC = 198000,
  parameter int ON_CYC  = 4400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic ss_done,
  input  logic static_mode,
  input  logic oc_det,
  output logic out_en,
  output logic olf
);
  localparam int MAX_CYC = (OFF_CYC > ON_CYC) ? OFF_CYC : ON_CYC;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             tmr_clr;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  hiccup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  hiccup_fsm #(.CNT_W(CNT_W), .OFF_CYC(OFF_CYC), .ON_CYC(ON_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_en     (chan_en),
    .ss_done     (ss_done),
    .static_mode (static_mode),
    .oc_det      (oc_det),
    .tmr_zero    (tmr_zero),
    .tmr_clr     (tmr_clr),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .out_en      (out_en),
    .olf         (olf)
  );
endmodule

// File: rtl/hiccup_ctrl_chk.sv
module hiccup_ctrl_chk #(
  parameter int OFF_CYC = 198000,
  parameter int ON_CYC  = 4400
) (
  input logic clk,
  input logic rst_n,
  input logic chan_en,
  input logic ss_done,
  input logic static_mode,
  input logic oc_det,
  input logic out_en,
  input logic olf
);
  localparam int RW = $clog2(OFF_CYC + 2);
  logic [RW-1:0] off_run;

  // length of the current stretch with the output removed and the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_run <= '0;
    else if (chan_en && !out_en && olf) begin
      if (off_run != RW'(OFF_CYC + 1)) off_run <= off_run + 1'b1;
    end else off_run <= '0;
  end

  a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!out_en && !olf));

  a_r3_softstart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !ss_done) |=> (out_en && !olf));

  a_r4_static_on: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && static_mode) |=> out_en);

  a_r4_static_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && ss_done && static_mode && out_en) |=> (olf == $past(oc_det)));

  a_r5_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && ss_done && !static_mode && oc_det && out_en && !olf) |=> (!out_en && olf));

  a_r10_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && ss_done && !static_mode && !out_en && olf) |=> olf);

  a_r6_off_length: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && off_run != 0 && !$past(static_mode) && $past(chan_en) && $past(ss_done))
      |-> (off_run == RW'(OFF_CYC)));
endmodule

bind hiccup_ctrl hiccup_ctrl_chk #(.OFF_CYC(OFF_CYC), .ON_CYC(ON_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ss_done(ss_done),
  .static_mode(static_mode), .oc_det(oc_det), .out_en(out_en), .olf(olf)
);

// File: tb/sim_hiccup_ctrl.sv
module sim_hiccup_ctrl;
  localparam int OFF_N = 20;
  localparam int ON_N  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0, ss_done = 1'b0, static_mode = 1'b0, oc_det = 1'b0;
  logic out_en, olf;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  hiccup_ctrl #(.OFF_CYC(OFF_N), .ON_CYC(ON_N)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ss_done(ss_done),
    .static_mode(static_mode), .oc_det(oc_det), .out_en(out_en), .olf(olf)
  );

  // {chan_en, ss_done, static_mode, oc_det, exp_out_en, exp_olf}
  localparam logic [5:0] VEC [0:10] = '{
    6'b0000_00, 6'b1001_10, 6'b1111_11, 6'b1110_10, 6'b1111_11, 6'b1100_10,
    6'b1101_01, 6'b1110_10, 6'b1101_01, 6'b0100_00, 6'b1100_10
  };
  localparam string VREQ [0:10] = '{
    "R2", "R3", "R4", "R4", "R4", "R4", "R5", "R9", "R5", "R2", "R2"
  };

  task automatic check(input logic eo, input logic ef, input string req);
    checks++;
    if (out_en !== eo || olf !== ef) begin
      errors++;
      $display("FAIL %s: out_en=%b olf=%b expected out_en=%b olf=%b at %0t",
               req, out_en, olf, eo, ef, $time);
    end
  endtask

  task automatic step(input logic c, input logic s, input logic m, input logic o,
                      input logic eo, input logic ef, input string req);
    chan_en = c; ss_done = s; static_mode = m; oc_det = o;
    @(posedge clk);
    @(negedge clk);
    check(eo, ef, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(1'b0, 1'b0, "R1 after reset");

    for (int i = 0; i < 11; i++)
      step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], VREQ[i]);

    // clean hiccup: trip, full rest, clean trial window
    step(1, 1, 0, 1, 0, 1, "R5 trip");
    for (int i = 1; i < OFF_N; i++) step(1, 1, 0, 0, 0, 1, "R6 rest/R10");
    step(1, 1, 0, 0, 1, 1, "R6 rest end");
    for (int i = 1; i < ON_N; i++) step(1, 1, 0, 0, 1, 1, "R10 trial");
    step(1, 1, 0, 0, 1, 0, "R7 clean window");
    step(1, 1, 0, 0, 1, 0, "R7 runs on");

    // failed retry: overload early in the window
    step(1, 1, 0, 1, 0, 1, "R5 trip");
    for (int i = 1; i < OFF_N; i++) step(1, 1, 0, 0, 0, 1, "R6 rest");
    step(1, 1, 0, 0, 1, 1, "R6 rest end");
    step(1, 1, 0, 1, 1, 1, "R8 overload in trial");
    for (int i = 2; i < ON_N; i++) step(1, 1, 0, 0, 1, 1, "R10 trial");
    step(1, 1, 0, 0, 0, 1, "R8 retrip at window end");
    for (int i = 1; i < OFF_N; i++) step(1, 1, 0, 0, 0, 1, "R8 second rest");
    step(1, 1, 0, 0, 1, 1, "R8 second trial");
    for (int i = 1; i < ON_N; i++) step(1, 1, 0, 0, 1, 1, "R10 trial");
    step(1, 1, 0, 0, 1, 0, "R7 recovered");

    // static_mode raised during a trial window
    step(1, 1, 0, 1, 0, 1, "R5 trip");
    for (int i = 1; i < OFF_N; i++) step(1, 1, 0, 0, 0, 1, "R6 rest");
    step(1, 1, 0, 0, 1, 1, "R6 rest end");
    step(1, 1, 1, 1, 1, 1, "R9 abort in trial");
    step(1, 1, 1, 0, 1, 0, "R4 follows");

    // soft-start drop hides overload
    step(1, 0, 0, 1, 1, 0, "R3 soft-start");

    // reset in the middle of a rest interval
    step(1, 1, 0, 1, 0, 1, "R5 trip");
    step(1, 1, 0, 0, 0, 1, "R10 rest");
    rst_n = 1'b0;
    #1;
    check(1'b0, 1'b0, "R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 1, 0, 0, 1, 0, "R2 restart after reset");

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end
endmodule